// File: doc/BRIEF.md
# DMA Buffer Descriptor Sequencer

This block steps one DMA channel through a fixed ring of buffer descriptors. Each slot holds a five-bit control byte and a one-bit "consumed" status that software reaches through a small register port. The data path fills the active buffer. When it reports the buffer complete, the sequencer marks the slot consumed and decides where to go next. It may advance, return to slot 0, stop (halted), or wait (paused). It can also pulse an interrupt.

Each time the engine lands on a slot, it spends one check cycle on that slot before it offers the buffer to the data path. A slot that was never marked valid stops the engine with an error. A slot still marked consumed from an earlier pass parks the engine in the paused state, also with an error. Software restarts a halted engine with a start command and a paused one with a resume command. The number of slots is a parameter and is shown on a read-only count output.

The data-path side is a valid/ready pair. `fill_ready` is high only while a slot is being filled. `buf_full` is the completion valid, and it counts only in a cycle where `fill_ready` is high. There is no back-pressure on the completion itself. After an accepted completion, `fill_ready` stays low for at least one cycle.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset the engine is halted at slot 0, `fill_ready`, `irq_pulse` and `err_flag` are 0, and every control and status byte reads 0.
- R2: A control write stores data bits 4:0 (bit0 valid, bit1 halt, bit2 loop-to-0, bit3 interrupt, bit4 pause), which read back zero-extended with `reg_rd_stat`=0. A status read returns the consumed bit in bit0. A status write of 0x00 clears the consumed bit, and any other status value leaves it unchanged. `desc_count` equals NUM_DESC.
- R3: `cmd_start` while halted leads to one check cycle, with `st_running`=1 and `fill_ready`=0. `fill_ready` then rises on the following edge. `cmd_start` is ignored unless halted, and `cmd_resume` is ignored unless paused.
- R4: A check on a slot whose valid bit is 0 sets `err_flag` and halts the engine at the same index, without raising `fill_ready`.
- R5: A check on a slot whose consumed bit is 1 sets `err_flag` and pauses the engine at the same index.
- R6: `buf_full` with `fill_ready` high sets the consumed bit of the current slot. `buf_full` with `fill_ready` low changes no index, state, status or interrupt.
- R7: After a completion on a slot other than the last, with halt and loop both 0, the index advances by one and a check follows.
- R8: On a slot other than the last, loop=1 sends the index to 0 and the engine keeps running, even when halt is also 1.
- R9: On a slot other than the last, halt=1 with loop=0 halts the engine with the index advanced by one.
- R10: On the last slot the index always becomes 0. With halt=0 the engine keeps running. With halt=1 it halts, whatever the loop bit is.
- R11: pause=1 on a completion that does not halt leaves the engine paused at the next index. `cmd_resume` then starts a check at that index.
- R12: `irq_pulse` is high for exactly the one cycle after an accepted completion whose interrupt bit is 1.
- R13: `err_flag` stays set until `err_clear` is asserted, and a new error in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_stat | input | 1 | 1 selects the status byte, 0 the control byte |
| reg_wr_idx | input | IDX_W | Slot written |
| reg_wr_data | input | 8 | Write data |
| reg_rd_idx | input | IDX_W | Slot read |
| reg_rd_stat | input | 1 | 1 reads the status byte, 0 the control byte |
| reg_rd_data | output | 8 | Combinational read data |
| desc_count | output | 8 | Number of slots (read-only) |
| cmd_start | input | 1 | Leave halted state |
| cmd_resume | input | 1 | Leave paused state |
| err_clear | input | 1 | Clear the sticky error flag |
| fill_ready | output | 1 | Current buffer may be filled |
| buf_full | input | 1 | Current buffer complete (counted only with fill_ready) |
| cur_idx | output | IDX_W | Current slot index |
| st_running | output | 1 | Checking or filling |
| st_halted | output | 1 | Halted |
| st_paused | output | 1 | Paused |
| irq_pulse | output | 1 | One-cycle interrupt |
| err_flag | output | 1 | Sticky error |

## Verification
Every result appears one edge after the stimulus that causes it. This covers the new index, the state, the consumed bit, `irq_pulse` and `err_flag`. `fill_ready` follows on the second edge, because the check cycle sits in between. Register reads are combinational. The bench drives inputs just after a falling edge and samples at the next falling edge, so the single rising edge in between is the one the requirement names. It then samples one more falling edge later to see a pulse drop or a ready rise.

// File: rtl/dma_desc_seq_pkg.sv
package dma_desc_seq_pkg;
  typedef enum logic [1:0] {S_HALT, S_CHECK, S_FILL, S_PAUSE} seq_state_t;
  typedef enum logic [1:0] {STEP_GO, STEP_HALT, STEP_PAUSE} step_kind_t;
  typedef struct packed {
    logic pause;
    logic irq;
    logic loop;
    logic halt;
    logic valid;
  } ctrl_t;
  localparam int CTRL_W = $bits(ctrl_t);
  localparam int BYTE_W = 8;
endpackage

// File: rtl/dma_desc_store.sv
module dma_desc_store
  import dma_desc_seq_pkg::*;
#(
  parameter int NUM_DESC = 8,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_stat,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              done_en,
  input  logic [IDX_W-1:0]  done_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_stat,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  look_idx,
  output ctrl_t             look_ctrl,
  output logic              look_used
);
  ctrl_t ctrl_q [NUM_DESC];
  logic  used_q [NUM_DESC];
  logic  stat_zero;

  assign stat_zero = (wr_data == '0);

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_slot
    logic hit_wr;
    logic hit_done;
    assign hit_wr   = wr_en && (wr_idx == IDX_W'(g));
    assign hit_done = done_en && (done_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[g] <= '0;
        used_q[g] <= 1'b0;
      end else begin
        if (hit_wr && !wr_stat) ctrl_q[g] <= ctrl_t'(wr_data[CTRL_W-1:0]);
        if (hit_done)
          used_q[g] <= 1'b1;
        else if (hit_wr && wr_stat && stat_zero)
          used_q[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    if (rd_stat) rd_data = {{(BYTE_W-1){1'b0}}, used_q[rd_idx]};
    else         rd_data = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q[rd_idx]};
  end

  assign look_ctrl = ctrl_q[look_idx];
  assign look_used = used_q[look_idx];
endmodule

// File: rtl/dma_next_step.sv
module dma_next_step
  import dma_desc_seq_pkg::*;
#(
  parameter int NUM_DESC = 8,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input  logic [IDX_W-1:0] idx,
  input  ctrl_t            ctrl,
  output logic [IDX_W-1:0] nxt_idx,
  output step_kind_t       kind
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DESC - 1);
  logic             is_last;
  logic [IDX_W-1:0] inc_idx;

  assign is_last = (idx == LAST);
  assign inc_idx = is_last ? '0 : idx + 1'b1;

  always_comb begin
    if (ctrl.loop) begin
      nxt_idx = '0;
      if (is_last && ctrl.halt) kind = STEP_HALT;
      else if (ctrl.pause)      kind = STEP_PAUSE;
      else                      kind = STEP_GO;
    end else if (ctrl.halt) begin
      nxt_idx = inc_idx;
      kind    = STEP_HALT;
    end else begin
      nxt_idx = inc_idx;
      kind    = ctrl.pause ? STEP_PAUSE : STEP_GO;
    end
  end
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
  import dma_desc_seq_pkg::*;
#(
  parameter int NUM_DESC = 8,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_wr_stat,
  input  logic [IDX_W-1:0]  reg_wr_idx,
  input  logic [7:0]        reg_wr_data,
  input  logic [IDX_W-1:0]  reg_rd_idx,
  input  logic              reg_rd_stat,
  output logic [7:0]        reg_rd_data,
  output logic [7:0]        desc_count,
  input  logic              cmd_start,
  input  logic              cmd_resume,
  input  logic              err_clear,
  output logic              fill_ready,
  input  logic              buf_full,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              st_running,
  output logic              st_halted,
  output logic              st_paused,
  output logic              irq_pulse,
  output logic              err_flag
);
  seq_state_t       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             irq_q;
  logic             err_q;
  ctrl_t            cur_ctrl;
  logic             cur_used;
  logic [IDX_W-1:0] nxt_idx;
  step_kind_t       nxt_kind;
  logic             accept;

  assign accept = (state_q == S_FILL) && buf_full;

  dma_desc_store #(.NUM_DESC(NUM_DESC)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_stat   (reg_wr_stat),
    .wr_idx    (reg_wr_idx),
    .wr_data   (reg_wr_data),
    .done_en   (accept),
    .done_idx  (idx_q),
    .rd_idx    (reg_rd_idx),
    .rd_stat   (reg_rd_stat),
    .rd_data   (reg_rd_data),
    .look_idx  (idx_q),
    .look_ctrl (cur_ctrl),
    .look_used (cur_used)
  );

  dma_next_step #(.NUM_DESC(NUM_DESC)) u_step (
    .idx     (idx_q),
    .ctrl    (cur_ctrl),
    .nxt_idx (nxt_idx),
    .kind    (nxt_kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_HALT;
      idx_q   <= '0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (err_clear) err_q <= 1'b0;
      unique case (state_q)
        S_HALT:  if (cmd_start) state_q <= S_CHECK;
        S_CHECK: begin
          if (!cur_ctrl.valid) begin
            err_q   <= 1'b1;
            state_q <= S_HALT;
          end else if (cur_used) begin
            err_q   <= 1'b1;
            state_q <= S_PAUSE;
          end else begin
            state_q <= S_FILL;
          end
        end
        S_FILL: if (buf_full) begin
          irq_q <= cur_ctrl.irq;
          idx_q <= nxt_idx;
          unique case (nxt_kind)
            STEP_HALT:  state_q <= S_HALT;
            STEP_PAUSE: state_q <= S_PAUSE;
            default:    state_q <= S_CHECK;
          endcase
        end
        S_PAUSE: if (cmd_resume) state_q <= S_CHECK;
        default: state_q <= S_HALT;
      endcase
    end
  end

  assign fill_ready = (state_q == S_FILL);
  assign st_running = (state_q == S_CHECK) || (state_q == S_FILL);
  assign st_halted  = (state_q == S_HALT);
  assign st_paused  = (state_q == S_PAUSE);
  assign cur_idx    = idx_q;
  assign irq_pulse  = irq_q;
  assign err_flag   = err_q;
  assign desc_count = 8'(NUM_DESC);
endmodule

// File: rtl/dma_desc_seq_chk.sv
module dma_desc_seq_chk #(
  parameter int NUM_DESC = 8,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             cmd_resume,
  input logic             err_clear,
  input logic             buf_full,
  input logic             fill_ready,
  input logic [IDX_W-1:0] cur_idx,
  input logic             st_running,
  input logic             st_halted,
  input logic             st_paused,
  input logic             irq_pulse,
  input logic             err_flag
);
  a_r1_one_state: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({st_running, st_halted, st_paused}) == 1);

  a_r3_ready_after_check: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_ready) |-> $past(st_running) && !$past(fill_ready));

  a_r3_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_halted && !cmd_start) |=> st_halted && $stable(cur_idx));

  a_r11_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_paused && !cmd_resume) |=> st_paused && $stable(cur_idx));

  a_r6_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !fill_ready) |=> $stable(cur_idx) && !irq_pulse);

  a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clear) |=> err_flag);
endmodule

bind dma_desc_seq dma_desc_seq_chk #(.NUM_DESC(NUM_DESC)) u_chk (.*);

// File: tb/dma_desc_seq_test.sv
module dma_desc_seq_test;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_stat = 0, rd_stat = 0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [7:0] wr_data = '0, rd_data, cnt;
  logic start = 0, resume = 0, eclr = 0, full = 0;
  logic ready, running, halted, paused, irq, err;
  logic [IW-1:0] idx;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_desc_seq #(.NUM_DESC(N)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_stat(wr_stat),
    .reg_wr_idx(wr_idx), .reg_wr_data(wr_data), .reg_rd_idx(rd_idx),
    .reg_rd_stat(rd_stat), .reg_rd_data(rd_data), .desc_count(cnt),
    .cmd_start(start), .cmd_resume(resume), .err_clear(eclr),
    .fill_ready(ready), .buf_full(full), .cur_idx(idx),
    .st_running(running), .st_halted(halted), .st_paused(paused),
    .irq_pulse(irq), .err_flag(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wreg(input bit st, input int i, input logic [7:0] d);
    wr_en = 1; wr_stat = st; wr_idx = IW'(i); wr_data = d;
    tick();
    wr_en = 0;
  endtask

  function automatic int rreg(input bit st, input int i);
    rd_stat = st; rd_idx = IW'(i);
    return 0;
  endfunction

  task automatic rd(input bit st, input int i, output int v);
    int dummy;
    dummy = rreg(st, i);
    #0.1;
    v = int'(rd_data);
  endtask

  task automatic pulse_start();
    start = 1; tick(); start = 0;
  endtask

  task automatic pulse_resume();
    resume = 1; tick(); resume = 0;
  endtask

  task automatic clear_all_stat();
    for (int i = 0; i < N; i++) wreg(1, i, 8'h00);
  endtask

  // drives one completion once ready is up; returns after the accepting edge
  task automatic fill(input string req);
    int w = 0;
    while (!ready && w < 6) begin tick(); w++; end
    chk(req, int'(ready), 1);
    full = 1; tick(); full = 0;
  endtask

  task automatic t_reset();
    int v;
    chk("R1", int'(halted), 1);
    chk("R1", int'(idx), 0);
    chk("R1", int'(ready), 0);
    chk("R1", int'(irq), 0);
    chk("R1", int'(err), 0);
    rd(0, 5, v); chk("R1", v, 0);
    rd(1, 5, v); chk("R1", v, 0);
    chk("R2", int'(cnt), N);
  endtask

  task automatic t_regs();
    int v;
    wreg(0, 3, 8'hFF);
    rd(0, 3, v); chk("R2", v, 8'h1F);
    wreg(0, 3, 8'h01);
    rd(0, 3, v); chk("R2", v, 8'h01);
  endtask

  task automatic t_invalid();
    pulse_start();
    chk("R3", int'(running), 1);
    chk("R3", int'(ready), 0);
    tick();
    chk("R4", int'(err), 1);
    chk("R4", int'(halted), 1);
    chk("R4", int'(ready), 0);
    chk("R4", int'(idx), 0);
    tick(); tick();
    chk("R13", int'(err), 1);
    eclr = 1; tick(); eclr = 0;
    chk("R13", int'(err), 0);
  endtask

  task automatic t_advance_halt();
    int v;
    wreg(0, 0, 8'h09);
    wreg(0, 1, 8'h03);
    pulse_start();
    tick();
    chk("R3", int'(ready), 1);
    fill("R7");
    chk("R12", int'(irq), 1);
    chk("R7", int'(idx), 1);
    chk("R7", int'(running), 1);
    tick();
    chk("R12", int'(irq), 0);
    rd(1, 0, v); chk("R6", v, 1);
    fill("R9");
    chk("R9", int'(halted), 1);
    chk("R9", int'(idx), 2);
    chk("R12", int'(irq), 0);
    pulse_resume(); tick();
    chk("R3", int'(halted), 1);
    full = 1; tick(); full = 0;
    chk("R6", int'(idx), 2);
    chk("R6", int'(irq), 0);
    rd(1, 2, v); chk("R6", v, 0);
  endtask

  task automatic t_loop_priority();
    wreg(0, 2, 8'h07);
    clear_all_stat();
    pulse_start(); tick();
    fill("R8");
    chk("R8", int'(idx), 0);
    chk("R8", int'(running), 1);
    chk("R8", int'(halted), 0);
    fill("R8");
    fill("R8");
    chk("R9", int'(halted), 1);
    chk("R9", int'(idx), 2);
  endtask

  task automatic t_stale_used();
    int v;
    wreg(0, 2, 8'h11);
    pulse_start(); tick();
    chk("R5", int'(paused), 1);
    chk("R5", int'(err), 1);
    chk("R5", int'(idx), 2);
    pulse_start(); tick();
    chk("R3", int'(paused), 1);
    eclr = 1; tick(); eclr = 0;
    wreg(1, 2, 8'h05);
    rd(1, 2, v); chk("R2", v, 1);
    wreg(1, 2, 8'h00);
    rd(1, 2, v); chk("R2", v, 0);
    pulse_resume(); tick();
    chk("R11", int'(ready), 1);
    chk("R13", int'(err), 0);
  endtask

  task automatic t_pause();
    fill("R11");
    chk("R11", int'(paused), 1);
    chk("R11", int'(idx), 3);
    tick();
    chk("R11", int'(paused), 1);
    pulse_resume(); tick();
    chk("R11", int'(ready), 1);
    chk("R11", int'(idx), 3);
  endtask

  task automatic t_last();
    for (int i = 4; i < N; i++) wreg(0, i, 8'h01);
    wreg(0, 0, 8'h03);
    clear_all_stat();
    for (int i = 3; i < N; i++) fill("R10");
    chk("R10", int'(idx), 0);
    chk("R10", int'(running), 1);
    tick();
    chk("R10", int'(ready), 1);
    fill("R10");
    chk("R9", int'(halted), 1);
    chk("R9", int'(idx), 1);
    clear_all_stat();
    for (int i = 1; i < N - 1; i++) wreg(0, i, 8'h01);
    wreg(0, N - 1, 8'h07);
    pulse_start();
    for (int i = 1; i < N; i++) fill("R10");
    chk("R10", int'(halted), 1);
    chk("R10", int'(idx), 0);
    chk("R10", int'(err), 0);
    clear_all_stat();
    wreg(0, N - 1, 8'h03);
    wreg(0, 0, 8'h01);
    pulse_start();
    for (int i = 0; i < N; i++) fill("R10");
    chk("R10", int'(halted), 1);
    chk("R10", int'(idx), 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_regs();
    t_invalid();
    t_advance_halt();
    t_loop_priority();
    t_stale_used();
    t_pause();
    t_last();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule